// File: doc/BRIEF.md
# Duplex-Aware FIFO DMA Request Logic

This block decides when a network controller asks the system bus for DMA service on its transmit FIFO and on its receive FIFO. It watches the free space of the transmit FIFO, the fill level of the receive FIFO, frame start and end markers on both sides, a per-byte strobe on both sides, and an end-of-frame status bit. From these it produces one registered transmit DMA request and one registered receive DMA request. On the receive side it also produces a one-cycle flush pulse for frames that have to be thrown away.

The duplex mode changes how the block behaves. In half-duplex mode a collision can still hit the first 64 bytes of a frame, so the block protects that window in two ways. On the transmit side, bytes already sent stay reserved in the FIFO until 64 of them have gone out, and the space they use does not count toward a refill. On the receive side, a frame in progress cannot trigger DMA until 64 of its bytes have arrived. In full-duplex mode both protections are off. A runt-accept bit gives half-duplex receive the same behaviour as full-duplex receive.

Each side has a 2-bit watermark select. The select picks a threshold of base shifted left by the select value.

Top module: `fifo_dma_req`

## Requirements
- R1: A watermark select value s (0..3) gives a threshold of WM_BASE << s bytes. With the default WM_BASE of 16 the thresholds are 16, 32, 64 and 128.
- R2: In full-duplex mode, `tx_dma_req` rises one clock edge after `tx_space` becomes greater than or equal to the transmit threshold. It falls one clock edge after `tx_space` drops below the threshold.
- R3: In half-duplex mode, while a transmit frame is open and fewer than WINDOW_BYTES bytes have been sent since `tx_frame_start`, the bytes sent so far are subtracted from `tx_space` before the comparison. When the count reaches WINDOW_BYTES, or when `tx_frame_end` is seen, the full `tx_space` counts again.
- R4: In full-duplex mode, `rx_dma_req` follows `rx_fill` >= receive threshold, no matter how many bytes the current frame holds.
- R5: In half-duplex mode with `runt_accept` low, while a receive frame is open and fewer than WINDOW_BYTES of its bytes have been counted, the watermark raises no request.
- R6: In half-duplex mode, once WINDOW_BYTES bytes of the open frame have been counted, the watermark raises `rx_dma_req` as in R4.
- R7: In half-duplex mode with `runt_accept` high, receive requests behave exactly as in full-duplex mode.
- R8: A frame end with `rx_frame_ok` high is accepted under either of two conditions: in full-duplex or runt-accept mode at any length, or in gated half-duplex mode once WINDOW_BYTES bytes have been counted. An accepted frame end raises `rx_dma_req` on the next edge, and the request holds until `rx_fill` reads zero.
- R9: In gated half-duplex mode, a frame that ends with fewer than WINDOW_BYTES counted bytes is dropped, whatever its status. A dropped frame gives a one-cycle `rx_flush` pulse on the next edge and raises no request. Bytes strobed in the same cycle as a frame end are not counted.
- R10: While `rst_n` is low, `tx_dma_req`, `rx_dma_req` and `rx_flush` are low and both frame byte counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1 = full-duplex, 0 = half-duplex |
| runt_accept | input | 1 | Half-duplex receive bypass of the 64-byte gate |
| tx_wm_sel | input | 2 | Transmit watermark select |
| rx_wm_sel | input | 2 | Receive watermark select |
| tx_space | input | LVL_W | Free bytes in transmit FIFO, counting sent bytes as free |
| tx_frame_start | input | 1 | Transmit frame begins |
| tx_frame_end | input | 1 | Transmit frame ends |
| tx_byte_sent | input | 1 | One byte handed to the MAC |
| rx_fill | input | LVL_W | Occupied bytes in receive FIFO |
| rx_frame_start | input | 1 | Receive frame begins (byte strobe in same cycle counts) |
| rx_frame_end | input | 1 | Receive frame ends |
| rx_frame_ok | input | 1 | Status qualifying `rx_frame_end` |
| rx_byte_in | input | 1 | One byte written into receive FIFO |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_flush | output | 1 | Pulse: discard the dropped frame's bytes |

## Verification
The bench builds the block with its defaults: FIFO_BYTES of 256 (a 9-bit level), WINDOW_BYTES of 64 and WM_BASE of 16. With these values every threshold, including 128, can be probed one byte above and one byte below. The 64-byte window is also short enough to cross by strobing single bytes. This lets the bench check the held-byte subtraction, the release at the window boundary, and runt frames on both sides of the 64-byte line in every duplex and runt-accept combination.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
    localparam int unsigned SEL_W = 2;
    localparam int unsigned N_WM  = 1 << SEL_W;

    typedef enum logic {
        FRM_IDLE = 1'b0,
        FRM_OPEN = 1'b1
    } frm_st_e;
endpackage

// File: rtl/wm_decode.sv
module wm_decode
    import fdr_pkg::*;
#(
    parameter int unsigned LVL_W   = 9,
    parameter int unsigned WM_BASE = 16
) (
    input  logic [SEL_W-1:0] sel,
    output logic [LVL_W:0]   thr
);
    logic [LVL_W:0] tbl [N_WM];

    for (genvar i = 0; i < N_WM; i++) begin : g_thr
        assign tbl[i] = (LVL_W + 1)'(WM_BASE << i);
    end

    assign thr = tbl[sel];
endmodule

// File: rtl/tx_req_ctl.sv
module tx_req_ctl
    import fdr_pkg::*;
#(
    parameter int unsigned LVL_W = 9,
    parameter int unsigned WIN   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_duplex,
    input  logic [LVL_W:0]   thr,
    input  logic [LVL_W-1:0] tx_space,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             byte_sent,
    output logic             tx_req
);
    localparam int unsigned CNT_W = $clog2(WIN + 1);
    localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN);

    typedef struct packed {
        frm_st_e          st;
        logic [CNT_W-1:0] sent;
        logic             req;
    } tx_state_t;

    tx_state_t q, d;
    logic [LVL_W-1:0] held;
    logic [LVL_W-1:0] eff;

    always_comb begin
        d    = q;
        held = '0;
        if (!full_duplex && q.st == FRM_OPEN && q.sent < WIN_C)
            held = LVL_W'(q.sent);
        eff   = (tx_space > held) ? (tx_space - held) : '0;
        d.req = ({1'b0, eff} >= thr);
        if (frame_start) begin
            d.st   = FRM_OPEN;
            d.sent = '0;
        end else if (frame_end) begin
            d.st   = FRM_IDLE;
            d.sent = '0;
        end else if (q.st == FRM_OPEN && byte_sent && q.sent < WIN_C) begin
            d.sent = q.sent + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: FRM_IDLE, sent: '0, req: 1'b0};
        else        q <= d;
    end

    assign tx_req = q.req;

    AST_TX_FD_WM: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex && ({1'b0, tx_space} >= thr) |=> tx_req); // R2
    AST_TX_BELOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, tx_space} < thr) |=> !tx_req); // R2
    AST_TX_WIN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        q.sent <= WIN_C); // R3
    AST_TX_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == FRM_IDLE) && !frame_start && ({1'b0, tx_space} >= thr) |=> tx_req); // R3
endmodule

// File: rtl/rx_req_ctl.sv
module rx_req_ctl
    import fdr_pkg::*;
#(
    parameter int unsigned LVL_W = 9,
    parameter int unsigned WIN   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_duplex,
    input  logic             runt_accept,
    input  logic [LVL_W:0]   thr,
    input  logic [LVL_W-1:0] rx_fill,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             frame_ok,
    input  logic             byte_in,
    output logic             rx_req,
    output logic             rx_flush
);
    localparam int unsigned CNT_W = $clog2(WIN + 1);
    localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN);

    typedef struct packed {
        frm_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic             req;
        logic             flush;
    } rx_state_t;

    rx_state_t q, d;
    logic bypass, gate_open, wm_hit, accept, drop;

    always_comb begin
        d         = q;
        bypass    = full_duplex | runt_accept;
        gate_open = bypass | (q.st == FRM_IDLE) | (q.cnt == WIN_C);
        wm_hit    = gate_open && ({1'b0, rx_fill} >= thr);
        accept    = frame_end && (q.st == FRM_OPEN) && frame_ok
                    && (bypass || q.cnt == WIN_C);
        drop      = frame_end && (q.st == FRM_OPEN) && !bypass && (q.cnt < WIN_C);

        if (accept)             d.pend = 1'b1;
        else if (rx_fill == '0) d.pend = 1'b0;

        d.flush = drop;
        d.req   = wm_hit | d.pend;

        if (frame_start) begin
            d.st  = FRM_OPEN;
            d.cnt = byte_in ? CNT_W'(1) : '0;
        end else if (frame_end) begin
            d.st  = FRM_IDLE;
            d.cnt = '0;
        end else if (q.st == FRM_OPEN && byte_in && q.cnt < WIN_C) begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: FRM_IDLE, cnt: '0, pend: 1'b0, req: 1'b0, flush: 1'b0};
        else        q <= d;
    end

    assign rx_req   = q.req;
    assign rx_flush = q.flush;

    AST_RX_FD_WM: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex && ({1'b0, rx_fill} >= thr) |=> rx_req); // R4
    AST_RX_GATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !full_duplex && !runt_accept && (q.st == FRM_OPEN) && (q.cnt < WIN_C)
        && !q.pend && !frame_start |=> !rx_req); // R5
    AST_RX_RUNT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        runt_accept && ({1'b0, rx_fill} >= thr) |=> rx_req); // R7
    AST_RX_ACCEPT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end && frame_ok && (q.st == FRM_OPEN) && (full_duplex || runt_accept)
        |=> rx_req); // R8
    AST_RX_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> !rx_flush); // R9
endmodule

// File: rtl/fifo_dma_req.sv
module fifo_dma_req
    import fdr_pkg::*;
#(
    parameter int unsigned FIFO_BYTES   = 256,
    parameter int unsigned WINDOW_BYTES = 64,
    parameter int unsigned WM_BASE      = 16,
    localparam int unsigned LVL_W       = $clog2(FIFO_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_duplex,
    input  logic             runt_accept,
    input  logic [SEL_W-1:0] tx_wm_sel,
    input  logic [SEL_W-1:0] rx_wm_sel,
    input  logic [LVL_W-1:0] tx_space,
    input  logic             tx_frame_start,
    input  logic             tx_frame_end,
    input  logic             tx_byte_sent,
    input  logic [LVL_W-1:0] rx_fill,
    input  logic             rx_frame_start,
    input  logic             rx_frame_end,
    input  logic             rx_frame_ok,
    input  logic             rx_byte_in,
    output logic             tx_dma_req,
    output logic             rx_dma_req,
    output logic             rx_flush
);
    logic [LVL_W:0] tx_thr;
    logic [LVL_W:0] rx_thr;

    wm_decode #(.LVL_W(LVL_W), .WM_BASE(WM_BASE)) u_tx_wm (
        .sel(tx_wm_sel), .thr(tx_thr)
    );
    wm_decode #(.LVL_W(LVL_W), .WM_BASE(WM_BASE)) u_rx_wm (
        .sel(rx_wm_sel), .thr(rx_thr)
    );

    tx_req_ctl #(.LVL_W(LVL_W), .WIN(WINDOW_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .thr(tx_thr),
        .tx_space(tx_space), .frame_start(tx_frame_start), .frame_end(tx_frame_end),
        .byte_sent(tx_byte_sent), .tx_req(tx_dma_req)
    );

    rx_req_ctl #(.LVL_W(LVL_W), .WIN(WINDOW_BYTES)) u_rx (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .runt_accept(runt_accept),
        .thr(rx_thr), .rx_fill(rx_fill), .frame_start(rx_frame_start),
        .frame_end(rx_frame_end), .frame_ok(rx_frame_ok), .byte_in(rx_byte_in),
        .rx_req(rx_dma_req), .rx_flush(rx_flush)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !tx_dma_req && !rx_dma_req && !rx_flush); // R10
endmodule

// File: tb/tb_fifo_dma_req.sv
`timescale 1ns/1ps
module tb_fifo_dma_req;
    localparam int unsigned LVL_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic full_duplex = 1'b0, runt_accept = 1'b0;
    logic [1:0] tx_wm_sel = 2'd0, rx_wm_sel = 2'd0;
    logic [LVL_W-1:0] tx_space = '0, rx_fill = '0;
    logic tx_frame_start = 1'b0, tx_frame_end = 1'b0, tx_byte_sent = 1'b0;
    logic rx_frame_start = 1'b0, rx_frame_end = 1'b0, rx_frame_ok = 1'b0, rx_byte_in = 1'b0;
    logic tx_dma_req, rx_dma_req, rx_flush;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fifo_dma_req dut (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .runt_accept(runt_accept),
        .tx_wm_sel(tx_wm_sel), .rx_wm_sel(rx_wm_sel), .tx_space(tx_space),
        .tx_frame_start(tx_frame_start), .tx_frame_end(tx_frame_end),
        .tx_byte_sent(tx_byte_sent), .rx_fill(rx_fill), .rx_frame_start(rx_frame_start),
        .rx_frame_end(rx_frame_end), .rx_frame_ok(rx_frame_ok), .rx_byte_in(rx_byte_in),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .rx_flush(rx_flush)
    );

    // {is_rx, full_duplex, sel[1:0], level[8:0], expected}
    localparam logic [13:0] VEC [0:11] = '{
        {1'b0, 1'b1, 2'd0, 9'd16,  1'b1},
        {1'b0, 1'b1, 2'd0, 9'd15,  1'b0},
        {1'b0, 1'b0, 2'd1, 9'd32,  1'b1},
        {1'b0, 1'b0, 2'd1, 9'd31,  1'b0},
        {1'b0, 1'b1, 2'd2, 9'd64,  1'b1},
        {1'b0, 1'b1, 2'd3, 9'd127, 1'b0},
        {1'b0, 1'b0, 2'd3, 9'd128, 1'b1},
        {1'b1, 1'b1, 2'd0, 9'd16,  1'b1},
        {1'b1, 1'b0, 2'd1, 9'd31,  1'b0},
        {1'b1, 1'b1, 2'd2, 9'd64,  1'b1},
        {1'b1, 1'b0, 2'd2, 9'd63,  1'b0},
        {1'b1, 1'b1, 2'd3, 9'd128, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        tick();
        tick();
    endtask

    task automatic tx_bytes(input int n);
        tx_byte_sent = 1'b1;
        repeat (n) tick();
        tx_byte_sent = 1'b0;
    endtask

    task automatic rx_bytes(input int n);
        rx_byte_in = 1'b1;
        repeat (n) tick();
        rx_byte_in = 1'b0;
    endtask

    task automatic pulse_tx_start();
        tx_frame_start = 1'b1; tick(); tx_frame_start = 1'b0;
    endtask

    task automatic pulse_rx_start();
        rx_frame_start = 1'b1; tick(); rx_frame_start = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        // R10: outputs stay low in reset even with full FIFO levels
        full_duplex = 1'b1;
        tx_space = 9'd256;
        rx_fill  = 9'd256;
        @(negedge clk);
        repeat (3) tick();
        check("R10 tx_dma_req in reset", tx_dma_req, 0);
        check("R10 rx_dma_req in reset", rx_dma_req, 0);
        check("R10 rx_flush in reset", rx_flush, 0);
        tx_space = '0;
        rx_fill  = '0;
        rst_n = 1'b1;
        settle();

        // R1 table walk (idle frames, so no window gating applies)
        for (int i = 0; i < 12; i++) begin
            logic [13:0] v;
            v = VEC[i];
            full_duplex = v[12];
            if (v[13]) begin
                tx_space = '0; rx_wm_sel = v[11:10]; rx_fill = v[9:1];
                settle();
                check("R1 rx threshold", rx_dma_req, int'(v[0]));
            end else begin
                rx_fill = '0; tx_wm_sel = v[11:10]; tx_space = v[9:1];
                settle();
                check("R1 tx threshold", tx_dma_req, int'(v[0]));
            end
        end
        rx_fill = '0; tx_space = '0;
        tx_wm_sel = 2'd0; rx_wm_sel = 2'd0;
        settle();

        // R2: deassert one edge after the level drops
        full_duplex = 1'b1;
        tx_space = 9'd20;
        settle();
        check("R2 tx rises", tx_dma_req, 1);
        tx_space = 9'd10;
        check("R2 tx still high before edge", tx_dma_req, 1);
        tick();
        check("R2 tx falls after one edge", tx_dma_req, 0);

        // R3: half-duplex held bytes
        full_duplex = 1'b0;
        tx_space = 9'd20;
        pulse_tx_start();
        tx_bytes(10);
        settle();
        check("R3 held bytes block tx", tx_dma_req, 0);
        full_duplex = 1'b1;
        settle();
        check("R2 full-duplex ignores held bytes", tx_dma_req, 1);
        full_duplex = 1'b0;
        settle();
        tx_bytes(54);
        settle();
        check("R3 released at 64 bytes", tx_dma_req, 1);
        tx_frame_end = 1'b1; tick(); tx_frame_end = 1'b0;
        pulse_tx_start();
        tx_bytes(5);
        settle();
        check("R3 new frame holds again", tx_dma_req, 0);
        tx_frame_end = 1'b1; tick(); tx_frame_end = 1'b0;
        settle();
        check("R3 frame end releases", tx_dma_req, 1);
        tx_space = '0;
        settle();

        // R5 / R6: half-duplex receive gate
        full_duplex = 1'b0; runt_accept = 1'b0;
        pulse_rx_start();
        rx_bytes(20);
        rx_fill = 9'd20;
        settle();
        check("R5 gate holds below 64", rx_dma_req, 0);
        rx_bytes(44);
        settle();
        check("R6 gate opens at 64", rx_dma_req, 1);
        rx_frame_end = 1'b1; rx_frame_ok = 1'b0; tick(); rx_frame_end = 1'b0;
        check("R9 no flush after 64 bytes", rx_flush, 0);
        rx_fill = '0;
        settle();

        // R4: full duplex ignores byte count
        full_duplex = 1'b1;
        pulse_rx_start();
        rx_bytes(20);
        rx_fill = 9'd20;
        settle();
        check("R4 full-duplex rx watermark", rx_dma_req, 1);
        rx_frame_end = 1'b1; rx_frame_ok = 1'b0; tick(); rx_frame_end = 1'b0;
        rx_fill = '0;
        settle();

        // R7: runt-accept bypass in half duplex
        full_duplex = 1'b0; runt_accept = 1'b1;
        pulse_rx_start();
        rx_bytes(20);
        rx_fill = 9'd20;
        settle();
        check("R7 runt-accept opens gate", rx_dma_req, 1);
        rx_frame_end = 1'b1; rx_frame_ok = 1'b0; tick(); rx_frame_end = 1'b0;
        check("R7 no flush with runt-accept", rx_flush, 0);
        rx_fill = '0;
        settle();

        // R8: short valid frame with bypass, held until drained
        pulse_rx_start();
        rx_bytes(10);
        rx_fill = 9'd10;
        tick();
        check("R8 below watermark before end", rx_dma_req, 0);
        rx_frame_end = 1'b1; rx_frame_ok = 1'b1; tick(); rx_frame_end = 1'b0;
        check("R8 valid short frame requests", rx_dma_req, 1);
        settle();
        check("R8 request held while data", rx_dma_req, 1);
        rx_fill = '0;
        settle();
        check("R8 request drops when drained", rx_dma_req, 0);

        // R8: gated half-duplex accepts a full-window frame
        runt_accept = 1'b0;
        pulse_rx_start();
        rx_bytes(70);
        rx_fill = 9'd10;
        tick();
        rx_frame_end = 1'b1; rx_frame_ok = 1'b1; tick(); rx_frame_end = 1'b0;
        check("R8 gated frame of 64+ accepted", rx_dma_req, 1);
        rx_fill = '0;
        settle();

        // R9: runt with good status is dropped in gated mode
        pulse_rx_start();
        rx_bytes(10);
        rx_fill = 9'd20;
        tick();
        rx_frame_end = 1'b1; rx_frame_ok = 1'b1; tick(); rx_frame_end = 1'b0;
        check("R9 flush pulse on runt", rx_flush, 1);
        check("R9 runt raises no request", rx_dma_req, 0);
        rx_fill = '0;
        tick();
        check("R9 flush lasts one cycle", rx_flush, 0);
        check("R9 no request after drop", rx_dma_req, 0);

        // R9: bad status short frame also dropped
        pulse_rx_start();
        rx_bytes(30);
        rx_frame_end = 1'b1; rx_frame_ok = 1'b0; tick(); rx_frame_end = 1'b0;
        check("R9 flush on bad short frame", rx_flush, 1);
        settle();

        done = 1'b1;
        summary();
    end
endmodule